// File: doc/BRIEF.md
# Signed 32-by-32 Iterative Divider

This unit divides a two's-complement dividend by a two's-complement divisor, both the same width. It returns a signed quotient, rounded toward zero, and a signed remainder. It also produces processor-style condition flags, per-destination register write enables and a trap request for a zero divisor. An issuing pipeline starts an operation with a one-cycle strobe. It supplies the two operands, the register indices for the quotient and remainder destinations, and the current extend flag. It then waits for the single-cycle completion pulse and uses the enables, flags and trap request in that cycle.

Internally the unit converts both operands to magnitudes and runs a restoring shift-subtract loop. By default the loop produces one quotient bit per cycle. A parameter can chain several steps per cycle. The unit then restores the signs. A zero divisor and the single unrepresentable case (most negative dividend over minus one) skip the loop and complete on the cycle after the strobe. Neither writes a destination. The controller has three states. ST_IDLE waits for a strobe. ST_RUN iterates. ST_FIN presents the result for one cycle. The transitions are:
- ST_IDLE to ST_RUN on a strobe with ordinary operands.
- ST_IDLE to ST_FIN on a strobe with a special operand pair.
- ST_RUN to ST_FIN after the last iteration.
- ST_FIN to ST_IDLE unconditionally.

Top module: `sdiv_unit`

## Requirements
- R1: For a non-zero divisor and no overflow, the quotient equals the dividend divided by the divisor, truncated toward zero. The remainder is non-zero only with the sign of the dividend, and dividend = quotient*divisor + remainder.
- R2: A strobe accepted while idle raises busy on the next cycle. With default parameters, done is high for exactly one cycle: 33 clock edges after acceptance for an ordinary divide, and 1 edge after acceptance for a zero divisor or overflow. Busy stays high through the done cycle and drops on the next cycle.
- R3: A strobe that arrives while busy is high, including the done cycle, is ignored. The running result is unchanged and no extra operation follows.
- R4: A zero divisor raises trap in the done cycle, asserts neither write enable, and drives N, Z and V to 0.
- R5: A dividend of 0x80000000 divided by 0xFFFFFFFF sets V in the done cycle, asserts neither write enable, and drives N and Z to 0.
- R6: For a valid result, N equals bit 31 of the quotient, Z is 1 exactly when the quotient is zero, V is 0, and the quotient write enable is 1.
- R7: C is 0 in every done cycle. X in the done cycle equals the extend input sampled at acceptance.
- R8: When the two destination indices are equal at acceptance, only the quotient write enable rises. Otherwise both rise for a valid result.
- R9: Outside the done cycle, trap and both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation strobe, accepted only while idle |
| dividend | input | 32 | Signed dividend |
| divisor | input | 32 | Signed divisor |
| q_idx | input | 4 | Quotient destination register index |
| r_idx | input | 4 | Remainder destination register index |
| x_in | input | 1 | Incoming extend flag |
| busy | output | 1 | Operation in progress, through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Signed quotient, meaningful for valid results |
| remainder | output | 32 | Signed remainder, meaningful for valid results |
| q_we | output | 1 | Quotient register write enable |
| r_we | output | 1 | Remainder register write enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag, always 0 |
| flag_x | output | 1 | Extend flag, passed through |
| trap | output | 1 | Divide-by-zero trap request |

## Verification
Two pairs of functions can fall in the same completion cycle:
- The equal-index suppression of the remainder write, and the special-operand suppression of both writes. The bench issues a zero divisor and the overflow pair with identical destination indices. It expects trap or V with no enable at all, rather than a lone quotient write.
- Completion and a new strobe. The bench holds start high through every busy cycle, including the done cycle. It judges that the result matches the first operands, that done arrives at the expected latency, and that busy falls right after done with no second operation launched.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sdiv_state_e;

    typedef enum logic [1:0] {
        RK_OK   = 2'd0,
        RK_ZERO = 2'd1,
        RK_OVF  = 2'd2
    } sdiv_kind_e;

endpackage

// File: rtl/sdiv_prep.sv
// Operand conditioning: magnitudes, result signs and special-case detection.
module sdiv_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output logic         neg_q,
    output logic         neg_r,
    output logic         zero_div,
    output logic         ovf
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MINUS_ONE = {W{1'b1}};

    always_comb begin
        // The most negative value maps to itself, which reads correctly as unsigned.
        a_mag    = a[W-1] ? (~a + 1'b1) : a;
        b_mag    = b[W-1] ? (~b + 1'b1) : b;
        neg_q    = a[W-1] ^ b[W-1];
        neg_r    = a[W-1];
        zero_div = (b == '0);
        ovf      = (a == MOST_NEG) && (b == MINUS_ONE);
    end
endmodule

// File: rtl/sdiv_step.sv
// One restoring shift-subtract step on unsigned magnitudes.
module sdiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] dmag,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        shifted = {rem_in, quo_in[W-1]};
        trial   = shifted - {1'b0, dmag};
        if (!trial[W]) begin
            rem_out = trial[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b1};
        end else begin
            rem_out = shifted[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sdiv_post.sv
// Sign restoration and quotient-derived flags.
module sdiv_post #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         neg_q,
    input  logic         neg_r,
    output logic [W-1:0] quo_s,
    output logic [W-1:0] rem_s,
    output logic         n_out,
    output logic         z_out
);
    always_comb begin
        quo_s = neg_q ? (~quo_mag + 1'b1) : quo_mag;
        rem_s = neg_r ? (~rem_mag + 1'b1) : rem_mag;
        n_out = quo_s[W-1];
        z_out = (quo_s == '0);
    end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
    import sdiv_pkg::*;
#(
    parameter int W     = 32,
    parameter int IDXW  = 4,
    parameter int STEPS = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [W-1:0]    dividend,
    input  logic [W-1:0]    divisor,
    input  logic [IDXW-1:0] q_idx,
    input  logic [IDXW-1:0] r_idx,
    input  logic            x_in,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    quotient,
    output logic [W-1:0]    remainder,
    output logic            q_we,
    output logic            r_we,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_v,
    output logic            flag_c,
    output logic            flag_x,
    output logic            trap
);
    localparam int ROUNDS = W / STEPS;
    localparam int CW     = $clog2(ROUNDS + 1);
    localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

    sdiv_state_e     state_q;
    logic [CW-1:0]   cnt_q;
    logic [W-1:0]    rem_q, quo_q, dmag_q;
    logic            negq_q, negr_q, x_q, same_q;
    sdiv_kind_e      kind_q;

    logic [W-1:0]    a_mag, b_mag;
    logic            p_negq, p_negr, p_zero, p_ovf;
    logic            accept;
    logic [W-1:0]    post_q, post_r;
    logic            post_n, post_z;

    logic [W-1:0]    rem_c [0:STEPS];
    logic [W-1:0]    quo_c [0:STEPS];

    sdiv_prep #(.W(W)) u_prep (
        .a        (dividend),
        .b        (divisor),
        .a_mag    (a_mag),
        .b_mag    (b_mag),
        .neg_q    (p_negq),
        .neg_r    (p_negr),
        .zero_div (p_zero),
        .ovf      (p_ovf)
    );

    assign rem_c[0] = rem_q;
    assign quo_c[0] = quo_q;

    generate
        for (genvar s = 0; s < STEPS; s++) begin : g_step
            sdiv_step #(.W(W)) u_step (
                .rem_in  (rem_c[s]),
                .quo_in  (quo_c[s]),
                .dmag    (dmag_q),
                .rem_out (rem_c[s+1]),
                .quo_out (quo_c[s+1])
            );
        end
    endgenerate

    sdiv_post #(.W(W)) u_post (
        .quo_mag (quo_q),
        .rem_mag (rem_q),
        .neg_q   (negq_q),
        .neg_r   (negr_q),
        .quo_s   (post_q),
        .rem_s   (post_r),
        .n_out   (post_n),
        .z_out   (post_z)
    );

    assign accept = (state_q == ST_IDLE) && start;

    // State register and iteration counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q   <= '0;
                        state_q <= (p_zero || p_ovf) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_FIN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Operand capture and iteration datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dmag_q <= '0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
            x_q    <= 1'b0;
            same_q <= 1'b0;
            kind_q <= RK_OK;
        end else if (accept) begin
            rem_q  <= '0;
            quo_q  <= a_mag;
            dmag_q <= b_mag;
            negq_q <= p_negq;
            negr_q <= p_negr;
            x_q    <= x_in;
            same_q <= (q_idx == r_idx);
            kind_q <= p_zero ? RK_ZERO : (p_ovf ? RK_OVF : RK_OK);
        end else if (state_q == ST_RUN) begin
            rem_q <= rem_c[STEPS];
            quo_q <= quo_c[STEPS];
        end
    end

    // Output decode.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = 1'b0;
        quotient  = post_q;
        remainder = post_r;
        q_we      = 1'b0;
        r_we      = 1'b0;
        flag_n    = 1'b0;
        flag_z    = 1'b0;
        flag_v    = 1'b0;
        flag_c    = 1'b0;
        flag_x    = 1'b0;
        trap      = 1'b0;
        if (state_q == ST_FIN) begin
            done   = 1'b1;
            flag_x = x_q;
            unique case (kind_q)
                RK_OK: begin
                    q_we   = 1'b1;
                    r_we   = !same_q;
                    flag_n = post_n;
                    flag_z = post_z;
                end
                RK_ZERO: trap   = 1'b1;
                RK_OVF:  flag_v = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
    parameter int W    = 32,
    parameter int IDXW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [W-1:0]    dividend,
    input logic [IDXW-1:0] q_idx,
    input logic [IDXW-1:0] r_idx,
    input logic            x_in,
    input logic            busy,
    input logic            done,
    input logic [W-1:0]    quotient,
    input logic [W-1:0]    remainder,
    input logic            q_we,
    input logic            r_we,
    input logic            flag_n,
    input logic            flag_z,
    input logic            flag_v,
    input logic            flag_c,
    input logic            flag_x,
    input logic            trap
);
    logic       seen_x, seen_same, seen_sign;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_x    <= 1'b0;
            seen_same <= 1'b0;
            seen_sign <= 1'b0;
        end else if (start && !busy) begin
            seen_x    <= x_in;
            seen_same <= (q_idx == r_idx);
            seen_sign <= dividend[W-1];
        end
    end

    assert_rem_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q_we && remainder != '0) |-> (remainder[W-1] == seen_sign));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_trap_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!q_we && !r_we && !flag_v && !flag_n && !flag_z));

    assert_no_overflow_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v |-> (!q_we && !r_we && !flag_n && !flag_z));

    assert_flags_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q_we |-> ((flag_n == quotient[W-1]) && (flag_z == (quotient == '0)) && !flag_v));

    assert_cx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flag_c && (flag_x == seen_x)));

    assert_same_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && seen_same) |-> !r_we);

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!q_we && !r_we && !trap));
endmodule

bind sdiv_unit sdiv_chk #(.W(W), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .q_idx     (q_idx),
    .r_idx     (r_idx),
    .x_in      (x_in),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .q_we      (q_we),
    .r_we      (r_we),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .flag_x    (flag_x),
    .trap      (trap)
);

// File: tb/sim_sdiv_unit.sv
module sim_sdiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic [3:0]  q_idx = '0;
    logic [3:0]  r_idx = '0;
    logic        x_in = 1'b0;
    logic        busy, done, q_we, r_we, trap;
    logic        flag_n, flag_z, flag_v, flag_c, flag_x;
    logic [31:0] quotient, remainder;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    sdiv_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .q_idx(q_idx), .r_idx(r_idx), .x_in(x_in),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
        .q_we(q_we), .r_we(r_we), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .flag_x(flag_x), .trap(trap)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One divide; optionally holds start high through the whole busy period.
    task automatic do_div(input logic [31:0] a, input logic [31:0] b,
                          input logic [3:0] qi, input logic [3:0] ri,
                          input logic x, input bit poke);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        bit     zr = (b == 32'd0);
        bit     ov = (a == 32'h8000_0000) && (b == 32'hFFFF_FFFF);
        longint eq = 0;
        longint er = 0;
        int     lat = (zr || ov) ? 1 : 33;
        int     k = 1;
        if (!zr && !ov) begin
            eq = sa / sb;
            er = sa % sb;
        end
        @(negedge clk);
        dividend = a; divisor = b; q_idx = qi; r_idx = ri; x_in = x; start = 1'b1;
        @(negedge clk);
        if (poke) begin
            dividend = ~a; divisor = 32'd3; q_idx = ~qi; r_idx = qi; x_in = ~x;
        end else begin
            start = 1'b0;
        end
        chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
        while (!done && k < 40) begin
            chk(!q_we && !r_we && !trap, "R9", "quiet before done",
                {q_we, r_we, trap}, 0);
            @(negedge clk);
            k++;
        end
        chk(k == lat, "R2", "done latency", k, lat);
        chk(busy == 1'b1, "R2", "busy in done cycle", busy, 1);
        chk(flag_c == 1'b0, "R7", "C flag", flag_c, 0);
        chk(flag_x == x, "R7", "X pass-through", flag_x, x);
        if (zr) begin
            chk(trap == 1'b1, "R4", "trap", trap, 1);
            chk(!q_we && !r_we, "R4", "no write on zero divisor", {q_we, r_we}, 0);
            chk(!flag_n && !flag_z && !flag_v, "R4", "NZV on zero divisor",
                {flag_n, flag_z, flag_v}, 0);
        end else if (ov) begin
            chk(flag_v == 1'b1, "R5", "V on overflow", flag_v, 1);
            chk(!q_we && !r_we && !trap, "R5", "no write on overflow", {q_we, r_we, trap}, 0);
            chk(!flag_n && !flag_z, "R5", "NZ on overflow", {flag_n, flag_z}, 0);
        end else begin
            chk(longint'($signed(quotient)) == eq, "R1", "quotient",
                longint'($signed(quotient)), eq);
            chk(longint'($signed(remainder)) == er, "R1", "remainder",
                longint'($signed(remainder)), er);
            chk(flag_n == (eq < 0), "R6", "N flag", flag_n, (eq < 0));
            chk(flag_z == (eq == 0), "R6", "Z flag", flag_z, (eq == 0));
            chk(flag_v == 1'b0 && trap == 1'b0, "R6", "V and trap clear", {flag_v, trap}, 0);
            chk(q_we == 1'b1, "R6", "quotient write", q_we, 1);
            chk(r_we == (qi != ri), "R8", "remainder write", r_we, (qi != ri));
        end
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0 && done == 1'b0, "R3", "idle after done, no relaunch",
            {busy, done}, 0);
        chk(!q_we && !r_we && !trap, "R9", "quiet after done", {q_we, r_we, trap}, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done, "R2", "reset busy/done", {busy, done}, 0);
        chk(!q_we && !r_we && !trap, "R9", "reset enables", {q_we, r_we, trap}, 0);
    endtask

    task automatic t_signs();
        do_div(32'd100, 32'd7, 4'd1, 4'd2, 1'b0, 1'b0);
        do_div(-32'sd100, 32'd7, 4'd1, 4'd2, 1'b1, 1'b0);
        do_div(32'd100, -32'sd7, 4'd3, 4'd4, 1'b0, 1'b0);
        do_div(-32'sd100, -32'sd7, 4'd3, 4'd4, 1'b1, 1'b0);
        do_div(32'd0, 32'd5, 4'd5, 4'd6, 1'b0, 1'b0);
        do_div(32'd6, -32'sd3, 4'd5, 4'd6, 1'b0, 1'b0);
    endtask

    task automatic t_extremes();
        do_div(32'h8000_0000, 32'd1, 4'd0, 4'd1, 1'b1, 1'b0);
        do_div(32'h8000_0000, 32'h8000_0000, 4'd0, 4'd1, 1'b0, 1'b0);
        do_div(32'd7, 32'h8000_0000, 4'd0, 4'd1, 1'b0, 1'b0);
        do_div(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd0, 4'd1, 1'b1, 1'b0);
        do_div(32'h8000_0000, 32'd3, 4'd0, 4'd1, 1'b0, 1'b0);
    endtask

    task automatic t_special();
        do_div(32'd5, 32'd0, 4'd2, 4'd3, 1'b1, 1'b0);
        do_div(32'h8000_0000, 32'hFFFF_FFFF, 4'd2, 4'd3, 1'b0, 1'b0);
        // R8 against R4/R5: equal indices must not revive a write
        do_div(32'd9, 32'd0, 4'd7, 4'd7, 1'b0, 1'b0);
        do_div(32'h8000_0000, 32'hFFFF_FFFF, 4'd7, 4'd7, 1'b1, 1'b0);
    endtask

    task automatic t_same_idx();
        do_div(32'd17, 32'd5, 4'd9, 4'd9, 1'b0, 1'b0);
        do_div(-32'sd17, 32'd5, 4'd9, 4'd10, 1'b1, 1'b0);
    endtask

    task automatic t_busy_poke();
        // R3: start held high through busy and done cycles
        do_div(32'd1000, 32'd33, 4'd1, 4'd2, 1'b1, 1'b1);
        do_div(32'd4, 32'd0, 4'd1, 4'd2, 1'b0, 1'b1);
    endtask

    task automatic t_patterns();
        logic [31:0] s = 32'h1234_5678;
        for (int i = 0; i < 12; i++) begin
            logic [31:0] a, b;
            s = s * 32'd1664525 + 32'd1013904223;
            a = s;
            s = s * 32'd1664525 + 32'd1013904223;
            b = (i % 3 == 0) ? (s >>> 20) : s;
            if (b == 32'd0) b = 32'd11;
            do_div(a, b, 4'(i), 4'(i + 1), i[0], 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_signs();
        t_extremes();
        t_special();
        t_same_idx();
        t_busy_poke();
        t_patterns();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule